// File: doc/BRIEF.md
# I2C SCL Bit-Rate Generator

This block produces the SCL waveform for an I2C master. It takes a reference clock, divides it by a selectable power of two, and times the low and the released (high) half of every SCL period in those divided ticks. Each half lasts its programmed count plus a fixed overhead. The overhead stands for the input synchronizer and the one-cycle noise filter that a real bus interface has in its path.

The released half is not timed from the moment the block lets go of SCL. Timing starts only once the synchronized SCL input has been seen high. A slow rising edge, or a slave that holds SCL low, therefore lengthens the period and does not shorten the high time. Two one-cycle strobes tell the rest of the master when to sample SDA (the middle of the high half) and when to change SDA (the first cycle of the low half).

The divider select and the two period counts sit in small configuration registers. These registers can be written only while the internal-reset control is held. Releasing that control starts a fresh period with a low half.

Top module: `scl_rate_gen`

## Requirements
- R1: The prescaled tick occurs once every 2^P reference cycles, where P is the 3-bit divider select; P=0 means every reference cycle.
- R2: Each low half of SCL (scl_drive_low=1) lasts exactly (L+K)*2^P reference cycles, where L is the effective low count and K is 4 when P=0 and 3 otherwise.
- R3: After SCL is released, the high half is timed from the first cycle in which scl_in is high. scl_drive_low returns to 1 exactly 3+(H+K)*2^P cycles after that cycle, where H is the effective high count.
- R4: If scl_in stays low for S extra cycles after release (clock stretching), the released time grows by exactly S cycles.
- R5: A period field of 0 acts as 1, the minimum legal count.
- R6: Register addresses are 0 for the divider select, 1 for the low count and 2 for the high count. The count registers store bits [4:0] of a write and always read bits [7:5] as 1. The divider select stores and reads bits [2:0].
- R7: Writes take effect only while soft_rst=1. With soft_rst=0 a write leaves every readback unchanged.
- R8: While soft_rst=1, enable=0 or run=0, SCL is released and no strobe fires from the next cycle on. On becoming active again, the block starts with a complete low half, even if it dropped out in the last cycle of a low half.
- R9: tick_shift is high for exactly one cycle per period: the first cycle of each low half.
- R10: tick_sample is high for exactly one cycle per period, at 3+floor((H+K)/2)*2^P-1 cycles after the first cycle in which scl_in is high.
- R11: After reset the divider select reads 0, the low count reads 8'hEA, the high count reads 8'hE8, and SCL is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable |
| run | input | 1 | Request to generate SCL periods |
| soft_rst | input | 1 | Internal-reset hold; opens the configuration registers to writes |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 2 | Configuration register address |
| wr_data | input | 8 | Configuration write data |
| rd_psel | output | 3 | Divider select readback |
| rd_lo | output | 8 | Low count readback |
| rd_hi | output | 8 | High count readback |
| scl_in | input | 1 | Observed SCL level on the bus |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| tick_sample | output | 1 | SDA sample strobe at mid-high |
| tick_shift | output | 1 | SDA update strobe at the start of low |

## Verification
Two events can meet in one cycle: a low half reaching its final prescaled tick, and an idle request (run falling). The bench sets a 5-cycle low half and drops run in the last cycle of that half. It then requires SCL released with no strobe on the next cycle, and no high half at all. When run returns, a complete new low half must follow, with tick_shift on its first cycle. Stretching and sampling are covered the same way: the strobe index moves by exactly the stretch length.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_WAIT = 2'd2,
      PH_HIGH = 2'd3
   } phase_t;

   // overhead added to each half-period, in prescaled ticks
   localparam int unsigned OVH_UNDIV = 4;
   localparam int unsigned OVH_DIV   = 3;

   // configuration addresses; software depends on these
   localparam logic [1:0] ADDR_PSEL = 2'd0;
   localparam logic [1:0] ADDR_LO   = 2'd1;
   localparam logic [1:0] ADDR_HI   = 2'd2;

endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
   import scl_rate_pkg::*;
#(
   parameter int PSEL_W   = 3,
   parameter int PER_W    = 5,
   parameter int REG_W    = 8,
   parameter int DEF_PSEL = 0,
   parameter int DEF_LO   = 10,
   parameter int DEF_HI   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   output logic [PSEL_W-1:0] psel_q,
   output logic [PER_W-1:0]  lo_q,
   output logic [PER_W-1:0]  hi_q,
   output logic [REG_W-1:0]  rd_lo,
   output logic [REG_W-1:0]  rd_hi
);
   localparam int PAD_W = REG_W - PER_W;
   localparam int NPER  = 2;

   logic [NPER*PER_W-1:0] per_bus;
   logic                  wr_ok;
   logic                  unused_wr_bits;

   assign wr_ok          = hold && wr_en;
   assign unused_wr_bits = ^wr_data[REG_W-1:PER_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         psel_q <= PSEL_W'(DEF_PSEL);
      else if (wr_ok && wr_addr == ADDR_PSEL)
         psel_q <= wr_data[PSEL_W-1:0];
   end

   for (genvar gi = 0; gi < NPER; gi++) begin : g_per
      localparam logic [1:0]       MY_ADDR = (gi == 0) ? ADDR_LO : ADDR_HI;
      localparam logic [PER_W-1:0] RST_V   = (gi == 0) ? PER_W'(DEF_LO) : PER_W'(DEF_HI);
      logic [PER_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= RST_V;
         else if (wr_ok && wr_addr == MY_ADDR)
            q <= wr_data[PER_W-1:0];
      end
      assign per_bus[gi*PER_W +: PER_W] = q;
   end

   assign lo_q  = per_bus[0 +: PER_W];
   assign hi_q  = per_bus[PER_W +: PER_W];
   assign rd_lo = {{PAD_W{1'b1}}, lo_q};
   assign rd_hi = {{PAD_W{1'b1}}, hi_q};

   a_r7_locked_cfg : assert property (@(posedge clk) disable iff (!rst_n)
      !hold |=> ($stable(psel_q) && $stable(lo_q) && $stable(hi_q)));

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
   parameter int PSEL_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [PSEL_W-1:0] psel,
   output logic              tick
);
   localparam int DIV_W = (2 ** PSEL_W) - 1;

   logic [DIV_W-1:0] pre_cnt;
   logic [DIV_W-1:0] mask;

   assign mask = ~({DIV_W{1'b1}} << psel);
   assign tick = (pre_cnt == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pre_cnt <= '0;
      else if (clr || tick)
         pre_cnt <= '0;
      else
         pre_cnt <= pre_cnt + 1'b1;
   end

   a_r1_undivided : assert property (@(posedge clk) disable iff (!rst_n)
      (psel == '0) |-> tick);

   a_r1_bounded : assert property (@(posedge clk) disable iff (!rst_n)
      (pre_cnt & ~mask) == '0);

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
   import scl_rate_pkg::*;
#(
   parameter int PSEL_W      = 3,
   parameter int PER_W       = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act,
   input  logic [PSEL_W-1:0] psel,
   input  logic [PER_W-1:0]  lo_field,
   input  logic [PER_W-1:0]  hi_field,
   input  logic              tick,
   input  logic              scl_in,
   output logic              pre_clr,
   output logic              scl_drive_low,
   output logic              tick_sample,
   output logic              tick_shift
);
   localparam int CNT_W = PER_W + 1;

   phase_t             state_q, state_d;
   logic [CNT_W-1:0]   cnt_q;
   logic [CNT_W-1:0]   len_lo, len_hi, half_hi, ovh;
   logic [PER_W-1:0]   eff_lo, eff_hi;
   logic [SYNC_STAGES-1:0] sync_q;
   logic               scl_hi;
   logic               first_q;
   logic               lo_done, hi_done;

   // field 0 is below the legal minimum and acts as 1
   assign eff_lo  = (lo_field == '0) ? PER_W'(1) : lo_field;
   assign eff_hi  = (hi_field == '0) ? PER_W'(1) : hi_field;
   assign ovh     = (psel == '0) ? CNT_W'(OVH_UNDIV) : CNT_W'(OVH_DIV);
   assign len_lo  = CNT_W'(eff_lo) + ovh;
   assign len_hi  = CNT_W'(eff_hi) + ovh;
   assign half_hi = len_hi >> 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sync_q <= '1;
      else
         sync_q <= {sync_q[SYNC_STAGES-2:0], scl_in};
   end
   assign scl_hi = sync_q[SYNC_STAGES-1];

   assign lo_done = tick && (cnt_q == len_lo - CNT_W'(1));
   assign hi_done = tick && (cnt_q == len_hi - CNT_W'(1));

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PH_IDLE: state_d = PH_LOW;
         PH_LOW:  if (lo_done) state_d = PH_WAIT;
         PH_WAIT: if (scl_hi)  state_d = PH_HIGH;
         PH_HIGH: if (hi_done) state_d = PH_LOW;
         default: state_d = PH_IDLE;
      endcase
      if (!act) state_d = PH_IDLE;
   end

   assign pre_clr = (state_d != state_q) || (state_q == PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PH_IDLE;
         cnt_q   <= '0;
         first_q <= 1'b0;
      end else begin
         state_q <= state_d;
         first_q <= (state_d == PH_LOW) && (state_q != PH_LOW);
         if (state_d != state_q || !act)
            cnt_q <= '0;
         else if (tick && (state_q == PH_LOW || state_q == PH_HIGH))
            cnt_q <= cnt_q + 1'b1;
      end
   end

   assign scl_drive_low = (state_q == PH_LOW);
   assign tick_shift    = first_q;
   assign tick_sample   = (state_q == PH_HIGH) && tick && (cnt_q == half_hi - CNT_W'(1));

   a_r8_idle_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      !act |=> (!scl_drive_low && !tick_sample && !tick_shift));

   a_r9_shift_in_low : assert property (@(posedge clk) disable iff (!rst_n)
      tick_shift |-> scl_drive_low);

   a_r10_sample_released : assert property (@(posedge clk) disable iff (!rst_n)
      tick_sample |-> !scl_drive_low);

   a_r2_cnt_bound : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_LOW) |-> (cnt_q < len_lo));

   a_r4_wait_for_rise : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_WAIT && !scl_hi && act) |=> (state_q == PH_WAIT));

   a_r9_r10_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tick_sample, tick_shift}));

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
   import scl_rate_pkg::*;
#(
   parameter int PSEL_W      = 3,
   parameter int PER_W       = 5,
   parameter int REG_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int DEF_PSEL    = 0,
   parameter int DEF_LO      = 10,
   parameter int DEF_HI      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              run,
   input  logic              soft_rst,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   output logic [PSEL_W-1:0] rd_psel,
   output logic [REG_W-1:0]  rd_lo,
   output logic [REG_W-1:0]  rd_hi,
   input  logic              scl_in,
   output logic              scl_drive_low,
   output logic              tick_sample,
   output logic              tick_shift
);
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (REG_W <= PER_W) begin : g_chk_reg
      $error("REG_W must exceed PER_W");
   end
   if (PSEL_W < 1 || PSEL_W > 4) begin : g_chk_psel
      $error("PSEL_W out of range");
   end
   if (DEF_LO >= 2 ** PER_W || DEF_HI >= 2 ** PER_W) begin : g_chk_def
      $error("default period does not fit PER_W");
   end

   logic [PSEL_W-1:0] psel_q;
   logic [PER_W-1:0]  lo_q, hi_q;
   logic              act, tick, pre_clr;

   assign act     = enable && run && !soft_rst;
   assign rd_psel = psel_q;

   scl_cfg_regs #(
      .PSEL_W(PSEL_W), .PER_W(PER_W), .REG_W(REG_W),
      .DEF_PSEL(DEF_PSEL), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .hold(soft_rst),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .psel_q(psel_q), .lo_q(lo_q), .hi_q(hi_q),
      .rd_lo(rd_lo), .rd_hi(rd_hi)
   );

   scl_prescaler #(.PSEL_W(PSEL_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .clr(pre_clr), .psel(psel_q), .tick(tick)
   );

   scl_phase_fsm #(
      .PSEL_W(PSEL_W), .PER_W(PER_W), .SYNC_STAGES(SYNC_STAGES)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .act(act), .psel(psel_q),
      .lo_field(lo_q), .hi_field(hi_q), .tick(tick), .scl_in(scl_in),
      .pre_clr(pre_clr), .scl_drive_low(scl_drive_low),
      .tick_sample(tick_sample), .tick_shift(tick_shift)
   );

endmodule

// File: tb/scl_rate_gen_tb.sv
`timescale 1ns/1ps
module scl_rate_gen_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       enable, run, soft_rst, wr_en;
   logic [1:0] wr_addr;
   logic [7:0] wr_data;
   logic [2:0] rd_psel;
   logic [7:0] rd_lo, rd_hi;
   logic       scl_in, scl_drive_low, tick_sample, tick_shift;
   logic       hold_low;

   int n_chk = 0;
   int n_err = 0;
   int lo_n, hi_n, samp_idx, samp_cnt, shift_cnt;

   always #2.5 clk = ~clk;

   // open-drain bus: low if the block drives it or a slave stretches it
   assign scl_in = ~scl_drive_low & ~hold_low;

   scl_rate_gen u_dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .run(run), .soft_rst(soft_rst),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_psel(rd_psel), .rd_lo(rd_lo), .rd_hi(rd_hi),
      .scl_in(scl_in), .scl_drive_low(scl_drive_low),
      .tick_sample(tick_sample), .tick_shift(tick_shift)
   );

   // {psel, lo, hi, stretch}
   localparam int NV = 9;
   localparam logic [16:0] VEC [NV] = '{
      {3'd0, 5'd10, 5'd8,  4'd0},
      {3'd1, 5'd5,  5'd6,  4'd0},
      {3'd2, 5'd1,  5'd2,  4'd0},
      {3'd0, 5'd31, 5'd31, 4'd0},
      {3'd3, 5'd3,  5'd1,  4'd0},
      {3'd0, 5'd0,  5'd0,  4'd0},
      {3'd7, 5'd1,  5'd1,  4'd0},
      {3'd0, 5'd4,  5'd6,  4'd9},
      {3'd2, 5'd7,  5'd3,  4'd5}
   };

   function automatic int half_len(input int v, input int p);
      return ((v == 0) ? 1 : v) + ((p == 0) ? 4 : 3);
   endfunction

   task automatic chk(input string tag, input int actual, input int expected);
      n_chk++;
      if (actual != expected) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_addr = 2'd3; wr_data = 8'h00;
   endtask

   task automatic set_cfg(input int p, input int lo, input int hi);
      soft_rst = 1'b1;
      @(negedge clk);
      wr(2'd0, 8'(p));
      wr(2'd1, 8'(lo));
      wr(2'd2, 8'(hi));
      soft_rst = 1'b0;
   endtask

   // measures one low half and the released half that follows it
   task automatic measure(input int s);
      do @(negedge clk); while (!tick_shift);
      hold_low = 1'b1;
      lo_n = 0; shift_cnt = 0;
      while (scl_drive_low) begin
         if (tick_shift) shift_cnt++;
         lo_n++;
         @(negedge clk);
      end
      hi_n = 0; samp_idx = -1; samp_cnt = 0;
      while (!scl_drive_low) begin
         if (hi_n == s) hold_low = 1'b0;
         if (tick_sample) begin samp_idx = hi_n; samp_cnt++; end
         hi_n++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      rst_n = 1'b0; enable = 1'b0; run = 1'b0; soft_rst = 1'b0;
      wr_en = 1'b0; wr_addr = 2'd3; wr_data = 8'h00; hold_low = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      chk("R11 psel", int'(rd_psel), 0);
      chk("R11 lo", int'(rd_lo), 'hEA);
      chk("R11 hi", int'(rd_hi), 'hE8);
      chk("R11 scl released", int'(scl_drive_low), 0);

      // R7 writes ignored without soft_rst
      wr(2'd1, 8'h03);
      wr(2'd0, 8'h05);
      chk("R7 lo unchanged", int'(rd_lo), 'hEA);
      chk("R7 psel unchanged", int'(rd_psel), 0);

      // R6 field positions and constant upper bits
      soft_rst = 1'b1;
      wr(2'd1, 8'h03);
      chk("R6 lo readback", int'(rd_lo), 'hE3);
      wr(2'd2, 8'h1F);
      chk("R6 hi readback", int'(rd_hi), 'hFF);
      wr(2'd0, 8'hFD);
      chk("R6 psel readback", int'(rd_psel), 5);

      // R8 soft_rst held keeps SCL released
      enable = 1'b1; run = 1'b1;
      begin
         int busy = 0;
         for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (scl_drive_low || tick_sample || tick_shift) busy++;
         end
         chk("R8 held quiet", busy, 0);
      end

      // vector table
      for (int v = 0; v < NV; v++) begin
         int p  = int'(VEC[v][16:14]);
         int lo = int'(VEC[v][13:9]);
         int hi = int'(VEC[v][8:4]);
         int s  = int'(VEC[v][3:0]);
         int ll = half_len(lo, p) * (1 << p);
         int lh = half_len(hi, p);
         set_cfg(p, lo, hi);
         measure(s);
         chk((lo == 0) ? "R5 R2 low length" : ((p != 0) ? "R1 R2 low length" : "R2 low length"),
             lo_n, ll);
         chk((s != 0) ? "R4 released length" : ((hi == 0) ? "R5 R3 released length" : "R3 released length"),
             hi_n, s + 3 + lh * (1 << p));
         chk("R10 sample position", samp_idx, s + 3 + (lh / 2) * (1 << p) - 1);
         chk("R10 sample count", samp_cnt, 1);
         chk("R9 shift count", shift_cnt, 1);
      end

      // R8 idle request in the last cycle of a low half
      set_cfg(0, 1, 1);
      do @(negedge clk); while (!tick_shift);
      repeat (4) @(negedge clk);
      chk("R8 still low at last cycle", int'(scl_drive_low), 1);
      run = 1'b0;
      begin
         int busy = 0;
         for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (scl_drive_low || tick_sample || tick_shift) busy++;
         end
         chk("R8 idle after coincident stop", busy, 0);
      end
      run = 1'b1;
      @(negedge clk);
      chk("R9 shift on restart", int'(tick_shift), 1);
      lo_n = 0;
      while (scl_drive_low) begin lo_n++; @(negedge clk); end
      chk("R8 full low after restart", lo_n, 5);

      // R8 enable low releases SCL
      do @(negedge clk); while (!tick_shift);
      enable = 1'b0;
      @(negedge clk);
      chk("R8 disabled released", int'(scl_drive_low), 0);
      enable = 1'b1;

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule